// File: doc/BRIEF.md
# Video raster timing generator

This block produces the horizontal and vertical timing of a standard-definition video encoder. A pixel-clock counter runs across each line, and a half-line counter runs across each field (or across a whole interlaced frame). The block decodes single-cycle line-start and field-start strobes, a field identifier, and scheduled subcarrier phase-reset pulses from these two counters. It also drives a forced-blanking flag.

A trigger input moves the whole raster. On a trigger, the pixel counter is loaded with a programmable horizontal phase, and the half-line counter is loaded with a signed, programmable vertical phase. Every later event therefore comes earlier by that amount: a larger value means less delay after the trigger. One system-select bit chooses the 60 Hz raster (1716-clock lines, 262-line base field) or the 50 Hz raster (1728-clock lines, 312-line base field). A field-length mode chooses between interlaced fields and two lengths of non-interlaced field.

Settings arrive through a byte-wide write port. They are held in a staging copy and only take effect at the next line start, so a line is never cut short part of the way through its count.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `hcount` and `vhalf` are 0, `line_start` and `field_start` are 1, and `field_id`, `sc_reset` and `blank_force` are 0. After reset all settings are zero: 60 Hz, interlaced, no subcarrier reset, both phases 0, blanking off.
- R2: The line length is LINE_LEN_60 clocks when system select is 0 and LINE_LEN_50 clocks when it is 1. `hcount` counts 0 up to length−1 and wraps. `line_start` is high exactly in the cycles where `hcount` is 0.
- R3: In the cycle after `trig` is sampled high, `hcount` equals the horizontal phase. A phase at or above the line length is clamped to length−1. With phase H>0, the next line start therefore comes length−H cycles after that cycle.
- R4: On `trig`, `vhalf` is loaded with the vertical phase V (0..31) when the sign bit is 0. It is loaded with (period−V) modulo period when the sign bit is 1. After that, `vhalf` advances by one at each half-line boundary (`hcount` becomes 0 or length/2) and wraps at the period.
- R5: With N base lines, the period in half lines is 4N+2 for field mode 00 (interlaced frame), 2N for mode 01, and 2N+2 for modes 10 and 11.
- R6: In mode 00, `field_id` is 1 while `vhalf` ≥ 2N+1 and 0 otherwise. In the other modes, `field_id` stays 0.
- R7: `field_start` is high on a half-line boundary cycle when `vhalf` is 0, or, in mode 00 only, when `vhalf` is 2N+1.
- R8: `sc_reset` depends on the subcarrier mode. Mode 00 gives no pulses. Mode 01 pulses on the 1st, 3rd, 5th… line start after reset or trigger. Mode 10 pulses on the 1st, 9th, 17th… field start. Mode 11 pulses on the 1st, 5th, 9th… field start.
- R9: `blank_force` follows the blanking bit of the active settings.
- R10: The write port has the following layout. Address 0 holds horizontal phase bits 7:0. Address 1, bits 2:0, holds horizontal phase bits 10:8. Address 2 holds the vertical phase in bits 4:0 and the sign in bit 7. Address 3 holds system select in bit 0, field mode in bits 2:1, subcarrier mode in bits 4:3 and blanking in bit 5. A write is staged, and it becomes active only at the next line wrap, that is, in the cycle where `line_start` rises.
- R11: When `trig` falls on the last clock of a line, the trigger load wins. No line start follows, and staged settings stay pending until the next real line wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Raster trigger; reloads both counters with the phases |
| wr_en | input | 1 | Write strobe for the settings port |
| wr_addr | input | 2 | Settings address |
| wr_data | input | 8 | Settings data |
| hcount | output | CW | Pixel position within the line |
| vhalf | output | VW | Half-line position within the field or frame |
| line_start | output | 1 | High in the first clock of each line |
| field_start | output | 1 | High in the first clock of each field |
| field_id | output | 1 | Second interlaced field indicator |
| sc_reset | output | 1 | Subcarrier phase-reset pulse |
| blank_force | output | 1 | Forced blanking flag |

## Verification
Two events can fall in the same cycle: a trigger can arrive in the very clock where the pixel counter would wrap and commit staged settings. The bench stages a new horizontal phase and watches `hcount` until it is one short of the last count. It then raises `trig` so that `trig` is sampled on the wrapping edge. The result is judged at the ports. `hcount` must show the old phase with no line start. Only after the next genuine line start may a second trigger show the new phase.

// File: rtl/raster_pkg.sv
// Shared types for the raster timing generator.
// Assumes a byte-wide settings port with four addresses.
package raster_pkg;
    localparam int TRIG_HW = 11;   // horizontal phase width
    localparam int VTRIG_W = 5;    // vertical phase width
    localparam int FC_W    = 3;    // field counter for the eight-field schedule

    typedef enum logic [1:0] {
        FL_INTERLACED = 2'b00,
        FL_SHORT      = 2'b01,
        FL_LONG_A     = 2'b10,
        FL_LONG_B     = 2'b11
    } field_mode_e;

    typedef enum logic [1:0] {
        SC_OFF          = 2'b00,
        SC_TWO_LINES    = 2'b01,
        SC_EIGHT_FIELDS = 2'b10,
        SC_FOUR_FIELDS  = 2'b11
    } sc_mode_e;

    typedef struct packed {
        logic [TRIG_HW-1:0] htrig;
        logic [VTRIG_W-1:0] vtrig;
        logic               vneg;
        logic               sys50;
        field_mode_e        fmode;
        sc_mode_e           scmode;
        logic               blank;
    } cfg_t;

    localparam logic [1:0] A_HLO  = 2'd0;
    localparam logic [1:0] A_HHI  = 2'd1;
    localparam logic [1:0] A_VERT = 2'd2;
    localparam logic [1:0] A_CTRL = 2'd3;
endpackage

// File: rtl/raster_cfg_regs.sv
// Settings store: a staging copy written from the port and an active copy
// loaded from it on each line wrap. Assumes commit is a one-cycle pulse.
module raster_cfg_regs
    import raster_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       commit,
    output cfg_t       active
);
    cfg_t staged;

    // Capture port writes into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_HLO:  staged.htrig[7:0] <= wr_data;
                A_HHI:  staged.htrig[TRIG_HW-1:8] <= wr_data[2:0];
                A_VERT: begin
                    staged.vtrig <= wr_data[VTRIG_W-1:0];
                    staged.vneg  <= wr_data[7];
                end
                A_CTRL: begin
                    staged.sys50  <= wr_data[0];
                    staged.fmode  <= field_mode_e'(wr_data[2:1]);
                    staged.scmode <= sc_mode_e'(wr_data[4:3]);
                    staged.blank  <= wr_data[5];
                end
            endcase
        end
    end

    // Move staged settings into use at a line wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (commit) begin
            active <= staged;
        end
    end
endmodule

// File: rtl/raster_hcount.sv
// Pixel counter across a line. A trigger loads the horizontal phase, clamped
// to the last count. Assumes line_len is even and at least 4.
module raster_hcount
    import raster_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig,
    input  logic [CW-1:0]      line_len,
    input  logic [TRIG_HW-1:0] htrig,
    output logic [CW-1:0]      hcount,
    output logic               wrap,
    output logic               half_adv
);
    logic [CW-1:0] last;
    logic [CW-1:0] half_m1;
    logic [CW-1:0] load_v;
    logic          at_end;

    // Decode the line end, the mid-line point and the clamped load value.
    always_comb begin
        last     = line_len - CW'(1);
        half_m1  = (line_len >> 1) - CW'(1);
        at_end   = (hcount >= last);
        load_v   = (32'(htrig) >= 32'(line_len)) ? last : CW'(htrig);
        wrap     = !trig && at_end;
        half_adv = !trig && (at_end || (hcount == half_m1));
    end

    // Count pixels, reload on trigger, wrap at the line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcount <= '0;
        end else if (trig) begin
            hcount <= load_v;
        end else if (at_end) begin
            hcount <= '0;
        end else begin
            hcount <= hcount + CW'(1);
        end
    end
endmodule

// File: rtl/raster_vcount.sv
// Half-line counter across a field or interlaced frame. It wraps at period,
// and a value left above a shrunken period wraps at the next step.
module raster_vcount #(
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          half_adv,
    input  logic [VW-1:0] period,
    input  logic [VW-1:0] load_v,
    output logic [VW-1:0] vhalf
);
    logic [VW-1:0] nxt;

    // Next half-line position.
    always_comb nxt = vhalf + VW'(1);

    // Reload on trigger, otherwise step at half-line boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vhalf <= '0;
        end else if (trig) begin
            vhalf <= load_v;
        end else if (half_adv) begin
            vhalf <= (nxt >= period) ? '0 : nxt;
        end
    end
endmodule

// File: rtl/raster_events.sv
// Decodes strobes and the field identifier from the two counters, and
// schedules subcarrier resets with a line parity bit and a field counter.
// Assumes bnd = 2N+1 for the active base line count N.
module raster_events
    import raster_pkg::*;
#(
    parameter int CW = 11,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [CW-1:0] hcount,
    input  logic [CW-1:0] line_len,
    input  logic [VW-1:0] vhalf,
    input  logic [VW-1:0] bnd,
    input  field_mode_e   fmode,
    input  sc_mode_e      scmode,
    output logic          line_start,
    output logic          field_start,
    output logic          field_id,
    output logic          sc_reset
);
    logic            lpar;
    logic [FC_W-1:0] fcnt;
    logic            hb;
    logic            ilace;

    // Line and field strobes plus field identifier.
    always_comb begin
        ilace       = (fmode == FL_INTERLACED);
        hb          = (hcount == '0) || (hcount == (line_len >> 1));
        line_start  = (hcount == '0);
        field_id    = ilace && (vhalf >= bnd);
        field_start = hb && ((vhalf == '0) || (ilace && (vhalf == bnd)));
    end

    // Select the subcarrier reset schedule.
    always_comb begin
        sc_reset = 1'b0;
        case (scmode)
            SC_OFF:          sc_reset = 1'b0;
            SC_TWO_LINES:    sc_reset = line_start && !lpar;
            SC_EIGHT_FIELDS: sc_reset = field_start && (fcnt == '0);
            SC_FOUR_FIELDS:  sc_reset = field_start && (fcnt[1:0] == 2'b00);
        endcase
    end

    // Track line parity and field count since reset or trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || trig) begin
            lpar <= 1'b0;
            fcnt <= '0;
        end else begin
            if (line_start)  lpar <= ~lpar;
            if (field_start) fcnt <= fcnt + FC_W'(1);
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
// Top of the raster timing generator. Derives line length, half-line period,
// field boundary and signed vertical load from the active settings.
// Assumes even line lengths and base line counts of at least 16.
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int LINE_LEN_60 = 1716,
    parameter int LINE_LEN_50 = 1728,
    parameter int LINES_60    = 262,
    parameter int LINES_50    = 312
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [$clog2((LINE_LEN_50 > LINE_LEN_60) ? LINE_LEN_50 : LINE_LEN_60)-1:0] hcount,
    output logic [$clog2(4 * ((LINES_50 > LINES_60) ? LINES_50 : LINES_60) + 2)-1:0] vhalf,
    output logic line_start,
    output logic field_start,
    output logic field_id,
    output logic sc_reset,
    output logic blank_force
);
    localparam int LMAX = (LINE_LEN_50 > LINE_LEN_60) ? LINE_LEN_50 : LINE_LEN_60;
    localparam int NMAX = (LINES_50 > LINES_60) ? LINES_50 : LINES_60;
    localparam int CW   = $clog2(LMAX);
    localparam int VW   = $clog2(4 * NMAX + 2);

    cfg_t          act;
    logic          wrap;
    logic          half_adv;
    logic [CW-1:0] line_len;
    logic [VW-1:0] period;
    logic [VW-1:0] bnd;
    logic [VW-1:0] vload;
    logic [31:0]   nl;
    logic [31:0]   per;

    // Raster geometry from the active settings.
    always_comb begin
        nl       = act.sys50 ? 32'(LINES_50) : 32'(LINES_60);
        line_len = act.sys50 ? CW'(LINE_LEN_50) : CW'(LINE_LEN_60);
        case (act.fmode)
            FL_INTERLACED: per = 32'd4 * nl + 32'd2;
            FL_SHORT:      per = 32'd2 * nl;
            default:       per = 32'd2 * nl + 32'd2;
        endcase
        period = VW'(per);
        bnd    = VW'(32'd2 * nl + 32'd1);
        vload  = (act.vneg && (act.vtrig != '0)) ? VW'(per - 32'(act.vtrig))
                                                  : VW'(act.vtrig);
    end

    // Blanking flag follows the active copy.
    always_comb blank_force = act.blank;

    raster_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (wrap),
        .active  (act)
    );

    raster_hcount #(.CW(CW)) u_h (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .line_len (line_len),
        .htrig    (act.htrig),
        .hcount   (hcount),
        .wrap     (wrap),
        .half_adv (half_adv)
    );

    raster_vcount #(.VW(VW)) u_v (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .half_adv (half_adv),
        .period   (period),
        .load_v   (vload),
        .vhalf    (vhalf)
    );

    raster_events #(.CW(CW), .VW(VW)) u_ev (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (trig),
        .hcount      (hcount),
        .line_len    (line_len),
        .vhalf       (vhalf),
        .bnd         (bnd),
        .fmode       (act.fmode),
        .scmode      (act.scmode),
        .line_start  (line_start),
        .field_start (field_start),
        .field_id    (field_id),
        .sc_reset    (sc_reset)
    );
endmodule

// File: rtl/raster_timing_chk.sv
// Temporal checks on the raster generator, attached to the top by bind.
module raster_timing_chk #(
    parameter int CW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig,
    input logic [CW-1:0] hcount,
    input logic [CW-1:0] line_len,
    input logic          line_start,
    input logic          field_start,
    input logic          field_id,
    input logic          sc_reset,
    input logic          blank_force
);
    // R2: the pixel position never leaves the active line
    a_r2_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        hcount < line_len);

    // R2: without a trigger the position steps by one or wraps to zero
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> (hcount == $past(hcount) + CW'(1)) || (hcount == '0));

    // R2: a line start lasts one clock
    a_r2_line_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !trig) |=> !line_start);

    // R7: a field start lasts one clock
    a_r7_field_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && !trig) |=> !field_start);

    // R8: a subcarrier reset lasts one clock
    a_r8_sc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_reset && !trig) |=> !sc_reset);

    // R6: the field identifier only moves at a field or line boundary
    a_r6_fid_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(trig) && (field_id != $past(field_id))) |-> (field_start || line_start));

    // R10: blanking changes only where a line begins
    a_r10_blank_at_line: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_force != $past(blank_force)) |-> line_start);
endmodule

bind raster_timing_gen raster_timing_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig),
    .hcount      (hcount),
    .line_len    (line_len),
    .line_start  (line_start),
    .field_start (field_start),
    .field_id    (field_id),
    .sc_reset    (sc_reset),
    .blank_force (blank_force)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
    localparam int L60 = 20;
    localparam int L50 = 24;
    localparam int N60 = 16;
    localparam int N50 = 18;
    localparam int CW  = $clog2(L50);
    localparam int VW  = $clog2(4 * N50 + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [CW-1:0] hcount;
    logic [VW-1:0] vhalf;
    logic          line_start, field_start, field_id, sc_reset, blank_force;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int base = 0;
    bit armed = 1'b0;
    int q[$];
    int g_h, g_v, g_neg, g_s50, g_fm, g_sm, g_blank;

    raster_timing_gen #(.LINE_LEN_60(L60), .LINE_LEN_50(L50),
                        .LINES_60(N60), .LINES_50(N50)) u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .trig(trig), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hcount(hcount), .vhalf(vhalf), .line_start(line_start),
        .field_start(field_start), .field_id(field_id), .sc_reset(sc_reset),
        .blank_force(blank_force));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic configure(int h, int v, int neg, int s50, int fm, int sm, int blank);
        g_h = h; g_v = v; g_neg = neg; g_s50 = s50; g_fm = fm; g_sm = sm; g_blank = blank;
        wr(0, h & 255);
        wr(1, (h >> 8) & 7);
        wr(2, (neg << 7) | v);
        wr(3, (blank << 5) | (sm << 3) | (fm << 1) | s50);
        repeat (30) @(posedge clk);
    endtask

    // Driver: predicts every event after a trigger and queues it.
    task automatic run_window(int w);
        int l, n, p, hc, v0, half, lc, fc;
        l = g_s50 ? L50 : L60;
        n = g_s50 ? N50 : N60;
        p = (g_fm == 0) ? 4*n+2 : (g_fm == 1) ? 2*n : 2*n+2;
        hc = (g_h >= l) ? l-1 : g_h;
        v0 = (g_neg != 0 && g_v != 0) ? p - g_v : g_v;
        half = l / 2;
        lc = 0; fc = 0;
        q.delete();
        for (int t = 0; t <= w-2; t++) begin
            int x, v, ls, fs, sc, fid;
            x = hc + t;
            v = (v0 + x/half - hc/half) % p;
            ls = (x % l == 0);
            fs = (x % half == 0) && (v == 0 || (g_fm == 0 && v == 2*n+1));
            fid = (g_fm == 0 && v >= 2*n+1);
            sc = (g_sm == 1 && ls && lc % 2 == 0) || (g_sm == 2 && fs && fc % 8 == 0) ||
                 (g_sm == 3 && fs && fc % 4 == 0);
            if (ls) lc++;
            if (fs) fc++;
            if (ls || fs || sc) q.push_back(t*16 + ls*8 + fs*4 + sc*2 + fid);
        end
        @(posedge clk); #1;
        trig = 1'b1; base = cyc + 1; armed = 1'b1;
        @(posedge clk); #1;
        trig = 1'b0;
        repeat (w-1) @(posedge clk);
        #1 armed = 1'b0;
        check(q.size() == 0, "R7 all predicted events seen", q.size(), 0);
    endtask

    // Monitor: compares observed events with the queue front.
    always @(negedge clk) begin
        if (armed && (cyc - base) >= 0 && (line_start || field_start || sc_reset)) begin
            int a, e;
            a = (cyc - base)*16 + int'(line_start)*8 + int'(field_start)*4 +
                int'(sc_reset)*2 + int'(field_id);
            e = (q.size() == 0) ? -1 : q.pop_front();
            check(a == e, "R2/R3/R4/R5/R6/R7/R8 event", a, e);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(hcount == 0, "R1 hcount", int'(hcount), 0);
        check(vhalf == 0, "R1 vhalf", int'(vhalf), 0);
        check(line_start == 1, "R1 line_start", int'(line_start), 1);
        check(field_start == 1, "R1 field_start", int'(field_start), 1);
        check(field_id == 0, "R1 field_id", int'(field_id), 0);
        check(sc_reset == 0, "R1 sc_reset", int'(sc_reset), 0);
        check(blank_force == 0, "R1 blank_force", int'(blank_force), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R5 R6 interlaced 60 Hz, zero phases
        configure(0, 0, 0, 0, 0, 0, 0);
        run_window(1400);
        // R3 R4 R8 positive phases, short fields, two-line resets, 50 Hz
        configure(7, 5, 0, 1, 1, 1, 0);
        run_window(1000);
        // R4 R8 negative phase, long fields, eight-field resets
        configure(3, 3, 1, 0, 2, 2, 0);
        run_window(3000);
        // R3 clamp of an oversized phase, four-field resets
        configure(2047, 31, 1, 1, 3, 3, 0);
        run_window(2400);
        // R6 R8 interlaced 50 Hz with eight-field resets
        configure(13, 20, 0, 1, 0, 2, 0);
        run_window(4200);

        // R9 R10 blanking write waits for the next line start
        do @(negedge clk); while (hcount != 3);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'((1 << 5) | (2 << 3) | (0 << 1) | 1);
        @(posedge clk); #1 wr_en = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (line_start) begin
                check(blank_force == 1, "R9 blank after line start", int'(blank_force), 1);
                break;
            end
            check(blank_force == 0, "R10 blank held until line start", int'(blank_force), 0);
        end

        // R11 trigger on the wrapping clock defers the staged phase
        configure(5, 0, 0, 0, 0, 0, 0);
        do @(negedge clk); while (hcount != 2);
        wr(0, 9);
        do @(negedge clk); while (hcount != L60-2);
        @(posedge clk); #1 trig = 1'b1;
        @(posedge clk); #1 trig = 1'b0;
        @(negedge clk);
        check(hcount == 5, "R11 old phase used at wrap", int'(hcount), 5);
        check(line_start == 0, "R11 no line start", int'(line_start), 0);
        do @(negedge clk); while (!line_start);
        @(posedge clk); #1 trig = 1'b1;
        @(posedge clk); #1 trig = 1'b0;
        @(negedge clk);
        check(hcount == 9, "R3 R10 staged phase active after wrap", int'(hcount), 9);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule